// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block decides when a vending machine hands out an item. It takes single-cycle pulses from a small-coin slot (2 units) and a large-coin slot (5 units), a buy button and a price word set from outside. It keeps the running credit and shows it on an output bus. When the buy button is pressed, it either hands out the item or signals that the purchase was refused.

The design has two parts. A control state machine turns the raw pulses into commands and produces the release and alarm pulses. A datapath holds the credit register, does the saturating add and the price subtraction, and reports back whether the credit covers the price. A purchase takes the price out of the credit. No change is returned.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `credit_o` to 0 and `release_o` and `alarm_o` to 0 after that edge.
- R2: A `coin_two_i` pulse sampled at an edge raises `credit_o` by 2 after that same edge.
- R3: A `coin_five_i` pulse sampled at an edge raises `credit_o` by 5 after that same edge.
- R4: When both coin inputs are high in the same cycle, only 2 is added.
- R5: Credit saturates at 2^SUM_W-1 (255 by default) and never wraps.
- R6: `buy_i` seen at an edge while the machine is idle and credit >= `price_i` raises `release_o` for exactly the one cycle after that edge, and `credit_o` drops by the price after that same edge.
- R7: `buy_i` seen while idle with credit < `price_i` raises `alarm_o` for exactly one cycle and leaves `credit_o` unchanged.
- R8: After a buy is taken, `buy_i` must be seen low at an edge before another purchase or alarm can happen. A held button gives a single pulse.
- R9: The price is read at the buy edge. A price of 0 always dispenses, and the credit is left as it was.
- R10: A coin that arrives in the same cycle as an accepted buy is still counted: the new credit is credit - price + coin.
- R11: `release_o` and `alarm_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| price_i | input | SUM_W | Item price in units |
| coin_two_i | input | 1 | One-cycle pulse for a 2-unit coin |
| coin_five_i | input | 1 | One-cycle pulse for a 5-unit coin |
| buy_i | input | 1 | Buy button level |
| release_o | output | 1 | One-cycle pulse that hands out the item |
| alarm_o | output | 1 | One-cycle pulse for a refused purchase |
| credit_o | output | SUM_W | Current credit |

## Verification
Every result comes from a register that is loaded at the edge where the stimulus is sampled. A coin, a buy or a reset therefore shows on `credit_o`, `release_o` and `alarm_o` exactly one edge after the inputs are applied. The bench drives its inputs on the falling edge and reads the outputs one time unit after the next rising edge, so each vector is checked in the cycle its result is due. When the button is held, the bench checks the following edges as well, to show that the pulse lasts only one cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;
   typedef enum logic [1:0] {
      COIN_NONE  = 2'd0,
      COIN_SMALL = 2'd1,
      COIN_LARGE = 2'd2
   } coin_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_HELD = 1'b1
   } buy_state_e;
endpackage

// File: rtl/vend_sat_add.sv
module vend_sat_add #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   logic [W:0] wide;

   assign wide = {1'b0, a_i} + {1'b0, b_i};

   generate
      if (SATURATE) begin : g_sat
         assign y_o = wide[W] ? MAXV : wide[W-1:0];
      end else begin : g_wrap
         assign y_o = wide[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
   import vend_pkg::*;
#(
   parameter int SUM_W    = 8,
   parameter int SMALL_V  = 2,
   parameter int LARGE_V  = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  coin_sel_e        coin_sel_i,
   input  logic             sub_en_i,
   input  logic [SUM_W-1:0] price_i,
   output logic             enough_o,
   output logic [SUM_W-1:0] credit_o
);
   localparam logic [SUM_W-1:0] MAXV   = {SUM_W{1'b1}};
   localparam logic [SUM_W-1:0] SMALLW = SUM_W'(SMALL_V);
   localparam logic [SUM_W-1:0] LARGEW = SUM_W'(LARGE_V);

   logic [SUM_W-1:0] credit_q, base, coin_val, next_credit;

   assign enough_o = (credit_q >= price_i);
   assign base     = sub_en_i ? (credit_q - price_i) : credit_q;

   always_comb begin
      unique case (coin_sel_i)
         COIN_SMALL: coin_val = SMALLW;
         COIN_LARGE: coin_val = LARGEW;
         default:    coin_val = '0;
      endcase
   end

   vend_sat_add #(.W(SUM_W), .SATURATE(1'b1)) i_add (
      .a_i(base),
      .b_i(coin_val),
      .y_o(next_credit)
   );

   always_ff @(posedge clk) begin
      if (rst) credit_q <= '0;
      else     credit_q <= next_credit;
   end

   assign credit_o = credit_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (coin_sel_i != COIN_NONE && !sub_en_i && credit_q == MAXV) |=> credit_q == MAXV); // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (coin_sel_i == COIN_NONE && !sub_en_i) |=> credit_q == $past(credit_q)); // R7
   AST_SUB_COVERED: assert property (@(posedge clk) disable iff (rst)
      sub_en_i |-> enough_o); // R6
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
   import vend_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      coin_two_i,
   input  logic      coin_five_i,
   input  logic      buy_i,
   input  logic      enough_i,
   output coin_sel_e coin_sel_o,
   output logic      sub_en_o,
   output logic      release_o,
   output logic      alarm_o
);
   buy_state_e state_q, state_d;
   logic       take;

   assign take = (state_q == ST_IDLE) && buy_i;

   always_comb begin
      if (coin_two_i)       coin_sel_o = COIN_SMALL;
      else if (coin_five_i) coin_sel_o = COIN_LARGE;
      else                  coin_sel_o = COIN_NONE;
   end

   assign sub_en_o = take && enough_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (buy_i)  state_d = ST_HELD;
         ST_HELD: if (!buy_i) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         release_o <= 1'b0;
         alarm_o   <= 1'b0;
      end else begin
         state_q   <= state_d;
         release_o <= take && enough_i;
         alarm_o   <= take && !enough_i;
      end
   end

   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(release_o && alarm_o)); // R11
   AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HELD) |=> (!release_o && !alarm_o)); // R8
   AST_REL_PULSE: assert property (@(posedge clk) disable iff (rst)
      release_o |=> !release_o); // R6
   AST_ALM_PULSE: assert property (@(posedge clk) disable iff (rst)
      alarm_o |=> !alarm_o); // R7
   AST_TWO_WINS: assert property (@(posedge clk) disable iff (rst)
      (coin_two_i && coin_five_i) |-> coin_sel_o == COIN_SMALL); // R4
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int SUM_W   = 8,
   parameter int SMALL_V = 2,
   parameter int LARGE_V = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SUM_W-1:0] price_i,
   input  logic             coin_two_i,
   input  logic             coin_five_i,
   input  logic             buy_i,
   output logic             release_o,
   output logic             alarm_o,
   output logic [SUM_W-1:0] credit_o
);
   localparam int MAX_CREDIT = (1 << SUM_W) - 1;

   initial begin
      assert (SUM_W >= 4 && SUM_W <= 24) else $error("SUM_W out of range");
      assert (SMALL_V > 0 && SMALL_V <= MAX_CREDIT) else $error("SMALL_V out of range");
      assert (LARGE_V > 0 && LARGE_V <= MAX_CREDIT) else $error("LARGE_V out of range");
   end

   coin_sel_e coin_sel;
   logic      sub_en, enough;

   vend_fsm i_fsm (
      .clk(clk), .rst(rst),
      .coin_two_i(coin_two_i), .coin_five_i(coin_five_i),
      .buy_i(buy_i), .enough_i(enough),
      .coin_sel_o(coin_sel), .sub_en_o(sub_en),
      .release_o(release_o), .alarm_o(alarm_o)
   );

   vend_datapath #(.SUM_W(SUM_W), .SMALL_V(SMALL_V), .LARGE_V(LARGE_V)) i_dp (
      .clk(clk), .rst(rst),
      .coin_sel_i(coin_sel), .sub_en_i(sub_en), .price_i(price_i),
      .enough_o(enough), .credit_o(credit_o)
   );

   AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (credit_o == '0 && !release_o && !alarm_o)); // R1
endmodule

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] price;
   logic       c2, c5, buy;
   logic       rel, alm;
   logic [7:0] cred;
   int         checks = 0;
   int         fails  = 0;
   bit         done   = 1'b0;

   always #4 clk = ~clk;

   vend_ctrl i_vend_ctrl (
      .clk(clk), .rst(rst), .price_i(price),
      .coin_two_i(c2), .coin_five_i(c5), .buy_i(buy),
      .release_o(rel), .alarm_o(alm), .credit_o(cred)
   );

   // {price[20:13], c2[12], c5[11], buy[10], rel[9], alarm[8], credit[7:0]}
   localparam logic [20:0] VEC [15] = '{
      {8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},   // R2
      {8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},   // R3
      {8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},   // R6
      {8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
      {8'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd0},   // R7
      {8'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},   // R4
      {8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},
      {8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd12},
      {8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd5},   // R6
      {8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},   // R8 held
      {8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},
      {8'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2},   // R10
      {8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},
      {8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2},   // R9
      {8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2}
   };

   task automatic check(input string req, input logic r, input logic a, input logic [7:0] c,
                        input logic er, input logic ea, input logic [7:0] ec);
      checks++;
      if (r !== er || a !== ea || c !== ec) begin
         fails++;
         $display("FAIL %s: rel=%0b alarm=%0b credit=%0d expected rel=%0b alarm=%0b credit=%0d",
                  req, r, a, c, er, ea, ec);
      end
   endtask

   task automatic step(input logic [7:0] p, input logic t, input logic f, input logic b);
      @(negedge clk);
      price = p; c2 = t; c5 = f; buy = b;
      @(posedge clk);
      #1;
   endtask

   initial begin
      rst = 1'b1; price = 8'd0; c2 = 1'b0; c5 = 1'b0; buy = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check("R1 reset", rel, alm, cred, 1'b0, 1'b0, 8'd0);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < 15; i++) begin
         step(VEC[i][20:13], VEC[i][12], VEC[i][11], VEC[i][10]);
         check($sformatf("vector %0d (R2 R3 R4 R6 R7 R8 R9 R10)", i), rel, alm, cred,
               VEC[i][9], VEC[i][8], VEC[i][7:0]);
      end

      // R8: held button with too little credit gives a single alarm
      step(8'd50, 1'b0, 1'b0, 1'b1);
      check("R8 first alarm", rel, alm, cred, 1'b0, 1'b1, 8'd2);
      step(8'd50, 1'b0, 1'b0, 1'b1);
      check("R8 held no repeat", rel, alm, cred, 1'b0, 1'b0, 8'd2);
      step(8'd50, 1'b0, 1'b0, 1'b1);
      check("R8 held no repeat", rel, alm, cred, 1'b0, 1'b0, 8'd2);
      step(8'd50, 1'b0, 1'b0, 1'b0);
      check("R7 credit kept", rel, alm, cred, 1'b0, 1'b0, 8'd2);

      // R5: saturation
      for (int k = 0; k < 60; k++) step(8'd0, 1'b0, 1'b1, 1'b0);
      check("R5 saturate five", rel, alm, cred, 1'b0, 1'b0, 8'd255);
      step(8'd0, 1'b1, 1'b0, 1'b0);
      check("R5 saturate two", rel, alm, cred, 1'b0, 1'b0, 8'd255);
      step(8'd255, 1'b0, 1'b0, 1'b1);
      check("R6 buy at max price", rel, alm, cred, 1'b1, 1'b0, 8'd0);
      step(8'd255, 1'b0, 1'b0, 1'b0);
      check("R6 one-cycle release", rel, alm, cred, 1'b0, 1'b0, 8'd0);

      // R11 boundary: exact price
      step(8'd5, 1'b0, 1'b1, 1'b0);
      step(8'd5, 1'b0, 1'b0, 1'b1);
      check("R6 R11 exact price", rel, alm, cred, 1'b1, 1'b0, 8'd0);
      step(8'd5, 1'b0, 1'b0, 1'b0);

      // R1: reset in mid-run clears credit
      step(8'd5, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1; c5 = 1'b0;
      @(posedge clk);
      #1;
      check("R1 mid-run reset", rel, alm, cred, 1'b0, 1'b0, 8'd0);
      @(negedge clk);
      rst = 1'b0;

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: done=0 expected done=1");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule